// File: doc/BRIEF.md
# Dual-Clock Width-Doubling FIFO

This block carries a stream of 32-bit words from one clock domain to another and hands them out as 64-bit words. Each 64-bit output word holds two consecutive input words. The write clock and the read clock are independent of each other. Only the two pointers cross between the domains, and each one crosses as a Gray-coded value through a two-stage synchroniser. Storage is split into two 32-bit halves that share one row address. The first word of each pair lands in the low half and the second word in the high half.

The write side reports how many 32-bit words are held, in an 11-bit count. That count wraps to zero when the store is completely full, so a separate full output tells the two zero cases apart. An almost-full output lets a source with two cycles of ready latency stop in time. It leaves margin for the count lag, the one-cycle write latency and the pairing granularity.

The read side reports how many complete 64-bit words it can deliver, in a 10-bit count. It also raises a near-full indicator when that count reads 1023. A single asynchronous clear empties both domains.

Top module: `wc_fifo_32to64`

## Requirements
- R1: While `aclr` is high, and after it falls with no traffic, the outputs are: `rd_empty`=1, `wr_used`=0, `rd_used`=0, `wr_full`=0, `wr_almost_full`=0, `rd_near_full`=0 and `rd_data`=0.
- R2: Each 64-bit read word is built from two consecutive accepted writes. The earlier write sits in bits [31:0] and the later one in bits [63:32]. Read words come out in write order.
- R3: `wr_used` equals the number of stored 32-bit words modulo 2048, so it reads 0 when all 2048 words are held. It reflects an accepted write on the second write-clock edge after the request is presented. The store takes the word on the first edge, and the count follows one edge later.
- R4: `wr_almost_full` is high whenever 2048 minus the stored word count is 6 or less. This includes the completely full state, in which `wr_used` reads 0. `wr_full` is high exactly when 2048 words are stored.
- R5: The read side counts only complete pairs. `rd_used` equals the stored pair count modulo 1024. `rd_empty` is high only when no complete pair is stored, and a lone odd word leaves it high.
- R6: `rd_near_full` is high exactly when `rd_used` reads 1023.
- R7: A write request while the store holds 2048 words is ignored. It changes neither the count nor any stored data.
- R8: A read request while `rd_empty` is high is ignored. It changes neither `rd_data` nor the read position.
- R9: `rd_data` is registered. It shows the requested word on the read-clock cycle after an accepted read and holds its value when no read is accepted.
- R10: With writes and reads running at the same time on unrelated clocks, and the source obeying `wr_almost_full`, every pair is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request for `wr_data` |
| wr_data | input | 32 | Input word |
| wr_used | output | 11 | Stored 32-bit words, wraps to 0 when full |
| wr_full | output | 1 | All 2048 word slots are occupied |
| wr_almost_full | output | 1 | Six or fewer free word slots |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request for the next 64-bit word |
| rd_data | output | 64 | Registered output word |
| rd_empty | output | 1 | No complete pair available |
| rd_used | output | 10 | Available complete pairs, modulo 1024 |
| rd_near_full | output | 1 | `rd_used` reads 1023 |
| aclr | input | 1 | Asynchronous clear of both domains |

## Verification
A push and a pop can land in the same moment. One happens on the write clock and the other on the read clock, and each domain sees the other's pointer only through its synchroniser. The bench provokes this overlap with a throttled writer on a 10 ns clock and an eager reader on a 14 ns clock, running concurrently. It judges the result by matching every delivered 64-bit word against the arithmetically generated pair sequence, and by requiring that almost-full stops the writer before any word is dropped. A separate near-exhaustive sweep fills a reduced store to every level from empty to completely full, then drains it. At each level it compares both counts and all flags with values computed from the level.

// File: rtl/wc_pkg.sv
`timescale 1ns/1ps
package wc_pkg;
    localparam int WC_WORD_W = 32;   // width of one input word
    localparam int WC_ADDR_W = 11;   // log2 of the capacity in input words
    localparam int WC_AF_GAP = 6;    // free-slot threshold for almost-full
endpackage

// File: rtl/wc_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a Gray-coded pointer
module wc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) sy_q <= '0;
        else      sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/wc_store.sv
`timescale 1ns/1ps
// Two half-width banks sharing a row address; registered 64-bit read
module wc_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic                wr_clk,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rd_clk,
    input  logic                aclr,
    input  logic                re,
    input  logic [ADDR_W-2:0]   raddr,
    output logic [2*DATA_W-1:0] rdata
);
    localparam int ROWS = 1 << (ADDR_W - 1);

    logic [DATA_W-1:0] half_q [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DATA_W-1:0] bank [ROWS];

        // Address bit 0 selects the bank: even words low, odd words high
        always_ff @(posedge wr_clk) begin
            if (we && (waddr[0] == 1'(h)))
                bank[waddr[ADDR_W-1:1]] <= wdata;
        end

        always_ff @(posedge rd_clk or posedge aclr) begin
            if (aclr)    half_q[h] <= '0;
            else if (re) half_q[h] <= bank[raddr];
        end
    end

    assign rdata = {half_q[1], half_q[0]};
endmodule

// File: rtl/wc_wr_ctrl.sv
`timescale 1ns/1ps
// Write-domain pointer, fill level and flags
module wc_wr_ctrl #(
    parameter int ADDR_W = 11,
    parameter int AF_GAP = 6
) (
    input  logic              clk,
    input  logic              aclr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] used,
    output logic              full,
    output logic              almost_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] AF_LEVEL = PW'(DEPTH - AF_GAP);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic [PW-1:0] level;
    } wst_t;

    wst_t st_d, st_q;
    logic [PW-1:0] rptr_words;
    logic [PW-1:0] fill_now;
    logic          full_now;
    logic          accept;

    function automatic logic [ADDR_W-1:0] g2b(input logic [ADDR_W-1:0] g);
        logic [ADDR_W-1:0] b;
        b[ADDR_W-1] = g[ADDR_W-1];
        for (int i = ADDR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        // Read pointer counts pairs; scale to word units
        rptr_words = {g2b(rgray_sync), 1'b0};
        fill_now   = st_q.wptr - rptr_words;
        full_now   = fill_now[ADDR_W];
        accept     = wr_en && !full_now;
        st_d       = st_q;
        st_d.wptr  = st_q.wptr + PW'(accept);
        st_d.wgray = st_d.wptr ^ (st_d.wptr >> 1);
        st_d.level = fill_now;               // published one edge later
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) st_q <= '0;
        else      st_q <= st_d;
    end

    assign wgray       = st_q.wgray;
    assign mem_we      = accept;
    assign mem_addr    = st_q.wptr[ADDR_W-1:0];
    assign used        = st_q.level[ADDR_W-1:0];
    assign full        = st_q.level[ADDR_W];
    assign almost_full = st_q.level >= AF_LEVEL;

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (aclr)
        fill_now <= PW'(DEPTH)); // R7
    AST_USED_STEP: assert property (@(posedge clk) disable iff (aclr)
        st_q.level <= $past(st_q.level) + PW'(1)); // R3
    AST_AF_BEFORE_FULL: assert property (@(posedge clk) disable iff (aclr)
        $rose(full) |-> $past(almost_full)); // R4
endmodule

// File: rtl/wc_rd_ctrl.sv
`timescale 1ns/1ps
// Read-domain pair pointer, availability and flags
module wc_rd_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              aclr,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic [ADDR_W-1:0] rgray,
    output logic              mem_re,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [ADDR_W-2:0] used,
    output logic              empty,
    output logic              near_full
);
    localparam int PW       = ADDR_W + 1;
    localparam int PR       = ADDR_W;
    localparam int RA_W     = ADDR_W - 1;
    localparam int RD_DEPTH = 1 << RA_W;

    typedef struct packed {
        logic [PR-1:0] rptr;
        logic [PR-1:0] rgray;
    } rst_t;

    rst_t st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PR-1:0] avail;
    logic          accept;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin       = g2b(wgray_sync);
        avail      = PR'(wbin >> 1) - st_q.rptr;  // complete pairs only
        empty      = (avail == '0);
        accept     = rd_en && !empty;
        st_d       = st_q;
        st_d.rptr  = st_q.rptr + PR'(accept);
        st_d.rgray = st_d.rptr ^ (st_d.rptr >> 1);
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) st_q <= '0;
        else      st_q <= st_d;
    end

    assign rgray     = st_q.rgray;
    assign mem_re    = accept;
    assign mem_addr  = st_q.rptr[RA_W-1:0];
    assign used      = avail[RA_W-1:0];
    assign near_full = (used == RA_W'(RD_DEPTH - 1));

    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (aclr)
        avail <= PR'(RD_DEPTH)); // R8
endmodule

// File: rtl/wc_fifo_32to64.sv
`timescale 1ns/1ps
module wc_fifo_32to64 import wc_pkg::*; #(
    parameter int WR_W   = WC_WORD_W,
    parameter int WA_W   = WC_ADDR_W,
    parameter int AF_GAP = WC_AF_GAP
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    output logic [WA_W-1:0]   wr_used,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [2*WR_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [WA_W-2:0]   rd_used,
    output logic              rd_near_full,
    input  logic              aclr
);
    logic [WA_W:0]   wgray, wgray_sync;
    logic [WA_W-1:0] rgray, rgray_sync;
    logic            mem_we, mem_re;
    logic [WA_W-1:0] waddr;
    logic [WA_W-2:0] raddr;

    wc_wr_ctrl #(.ADDR_W(WA_W), .AF_GAP(AF_GAP)) u_wr (
        .clk(wr_clk), .aclr(aclr), .wr_en(wr_en), .rgray_sync(rgray_sync),
        .wgray(wgray), .mem_we(mem_we), .mem_addr(waddr), .used(wr_used),
        .full(wr_full), .almost_full(wr_almost_full));

    wc_sync #(.W(WA_W + 1)) u_w2r (
        .clk(rd_clk), .aclr(aclr), .din(wgray), .dout(wgray_sync));

    wc_sync #(.W(WA_W)) u_r2w (
        .clk(wr_clk), .aclr(aclr), .din(rgray), .dout(rgray_sync));

    wc_rd_ctrl #(.ADDR_W(WA_W)) u_rd (
        .clk(rd_clk), .aclr(aclr), .rd_en(rd_en), .wgray_sync(wgray_sync),
        .rgray(rgray), .mem_re(mem_re), .mem_addr(raddr), .used(rd_used),
        .empty(rd_empty), .near_full(rd_near_full));

    wc_store #(.DATA_W(WR_W), .ADDR_W(WA_W)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .aclr(aclr), .re(mem_re), .raddr(raddr),
        .rdata(rd_data));

    AST_RD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (aclr)
        !(rd_en && !rd_empty) |=> $stable(rd_data)); // R9
endmodule

// File: tb/test_wc_fifo_32to64.sv
`timescale 1ns/1ps
module test_wc_fifo_32to64;
    localparam int WR_W   = 32;
    localparam int WA_W   = 5;
    localparam int AF_GAP = 6;
    localparam int DEPTH  = 1 << WA_W;
    localparam int RDEP   = DEPTH / 2;
    localparam int NP     = 100;

    logic              wr_clk = 0, rd_clk = 0, aclr = 1;
    logic              wr_en = 0, rd_en = 0;
    logic [WR_W-1:0]   wr_data = '0;
    logic [WA_W-1:0]   wr_used;
    logic              wr_full, wr_almost_full;
    logic [2*WR_W-1:0] rd_data;
    logic              rd_empty, rd_near_full;
    logic [WA_W-2:0]   rd_used;

    int checks = 0, fails = 0;

    always #5 wr_clk = ~wr_clk;   // 100 MHz
    always #7 rd_clk = ~rd_clk;

    wc_fifo_32to64 #(.WR_W(WR_W), .WA_W(WA_W), .AF_GAP(AF_GAP)) i_wc_fifo_32to64 (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_used(wr_used),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .rd_used(rd_used), .rd_near_full(rd_near_full), .aclr(aclr));

    function automatic logic [31:0] word(input int n, input int i);
        return {8'(n), 8'(i), 16'hA5C3 ^ 16'(i * 37)};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge wr_clk); aclr = 1;
        repeat (2) @(negedge rd_clk);
        @(negedge wr_clk); aclr = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge wr_clk); wr_en = 1; wr_data = d;
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic pop_check(input logic [63:0] exp, input string req);
        @(negedge rd_clk); rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic check_levels(input int n, input string tag);
        int p;
        p = n / 2;
        @(negedge wr_clk);
        chk(wr_used == WA_W'(n % DEPTH), {"R3 wr_used ", tag}, 64'(wr_used), 64'(n % DEPTH));
        chk(wr_full == (n == DEPTH), {"R4 wr_full ", tag}, 64'(wr_full), 64'(n == DEPTH));
        chk(wr_almost_full == (DEPTH - n <= AF_GAP), {"R4 almost_full ", tag},
            64'(wr_almost_full), 64'(DEPTH - n <= AF_GAP));
        @(negedge rd_clk);
        chk(rd_used == (WA_W-1)'(p % RDEP), {"R5 rd_used ", tag}, 64'(rd_used), 64'(p % RDEP));
        chk(rd_empty == (p == 0), {"R5 rd_empty ", tag}, 64'(rd_empty), 64'(p == 0));
        chk(rd_near_full == (p % RDEP == RDEP - 1), {"R6 rd_near_full ", tag},
            64'(rd_near_full), 64'(p % RDEP == RDEP - 1));
    endtask

    initial begin : watchdog
        #1500000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        #1;
        // R1: state during clear
        chk(rd_empty === 1'b1 && wr_used === '0 && rd_data === '0, "R1 during clear",
            {rd_empty, 31'(wr_used), 32'(rd_data)}, {1'b1, 63'd0});
        do_reset();
        settle();
        chk(rd_empty === 1 && rd_used === '0 && rd_near_full === 0 && rd_data === '0,
            "R1 read side after clear", {rd_empty, rd_near_full, 62'(rd_used)}, 64'h8000_0000_0000_0000);
        chk(wr_used === '0 && wr_full === 0 && wr_almost_full === 0,
            "R1 write side after clear", {wr_full, wr_almost_full, 62'(wr_used)}, 64'd0);

        // R3: count follows one edge after the store accepts the word
        @(negedge wr_clk); wr_en = 1; wr_data = 32'h1234_5678;
        @(negedge wr_clk); wr_en = 0;
        chk(wr_used == 0, "R3 count lag first edge", 64'(wr_used), 64'd0);
        @(negedge wr_clk);
        chk(wr_used == 1, "R3 count after second edge", 64'(wr_used), 64'd1);
        settle();
        chk(rd_empty == 1, "R5 single odd word not visible", 64'(rd_empty), 64'd1);

        // R8: reads on empty are ignored
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        chk(rd_data === '0, "R8 rd_data kept on empty read", rd_data, 64'd0);
        push(32'h9ABC_DEF0);
        settle();
        chk(rd_used == 1 && rd_empty == 0, "R8 read position intact", 64'(rd_used), 64'd1);
        pop_check({32'h9ABC_DEF0, 32'h1234_5678}, "R2 R8 first pair after empty reads");
        repeat (3) @(negedge rd_clk);
        chk(rd_data === {32'h9ABC_DEF0, 32'h1234_5678}, "R9 data holds without read",
            rd_data, {32'h9ABC_DEF0, 32'h1234_5678});

        // Sweep every fill level of the reduced store
        for (int n = 0; n <= DEPTH; n++) begin
            do_reset();
            settle();
            for (int i = 0; i < n; i++) begin
                @(negedge wr_clk); wr_en = 1; wr_data = word(n, i);
            end
            @(negedge wr_clk); wr_en = 0;
            if (n == DEPTH) begin
                // R7: writes while full are dropped
                for (int k = 0; k < 3; k++) begin
                    @(negedge wr_clk); wr_en = 1; wr_data = 32'hDEAD_0000 | k;
                end
                @(negedge wr_clk); wr_en = 0;
            end
            settle();
            check_levels(n, $sformatf("fill %0d", n));
            for (int k = 0; k < n / 2; k++)
                pop_check({word(n, 2*k+1), word(n, 2*k)},
                          (n == DEPTH) ? "R7 R2 data after full writes" : "R2 pair order");
            settle();
            check_levels(n % 2, $sformatf("drained %0d", n));
        end

        // R10: concurrent write and read
        do_reset();
        settle();
        fork
            begin
                for (int i = 0; i < 2 * NP; i++) begin
                    @(negedge wr_clk);
                    while (wr_almost_full) begin
                        wr_en = 0;
                        @(negedge wr_clk);
                    end
                    wr_en = 1; wr_data = word(99, i);
                end
                @(negedge wr_clk); wr_en = 0;
            end
            begin
                int  got;
                bit  pend;
                got = 0; pend = 0;
                while (got < NP) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        chk(rd_data === {word(99, 2*got+1), word(99, 2*got)},
                            "R10 concurrent stream", rd_data,
                            {word(99, 2*got+1), word(99, 2*got)});
                        got++;
                    end
                    rd_en = !rd_empty && (got < NP);
                    pend  = rd_en;
                end
                rd_en = 0;
            end
        join
        settle();
        chk(rd_empty == 1 && wr_used == 0, "R10 all delivered", {rd_empty, 63'(wr_used)},
            64'h8000_0000_0000_0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule